// File: doc/BRIEF.md
# AC-link Controller Serial Engine

This block runs the controller end of an AC-link in pass-through form. It counts the codec's bit clock to build a 256-bit frame, raises the sync output for the first 16 bit times of every frame, and moves 13 slots each way. Outbound slot words come one at a time from a transmit FIFO read port. Inbound slots are assembled into 32-bit words and written to a receive FIFO write port. The engine neither builds nor checks slot tags. Software supplies every slot, the control slots included, and reads every received slot back.

Each frame opens with slot 0, which is 16 bits. Slots 1 to 12 follow at 20 bits each. A slot word is left-aligned in its 32-bit container, so bit 31 is the first bit on the wire. The first received bit of each frame is the codec-ready flag, and it gates both directions. Received slots are kept only from frames whose flag is 1. Transmission begins with the frame after a ready frame, because the current frame is already under way. It ends after the frame whose flag is 0. A slot for which the FIFO has no word goes out as zeros and sets a sticky underrun flag.

Top module: `ac_link_engine`

## Requirements
- R1: While enabled, sync_o is high for 16 cycles and low for 240, with a period of 256 cycles. The first high cycle is the first enabled cycle (frame cycle 0).
- R2: In a frame whose transmit gate is closed, sdo_o stays 0 and tx_ready_o never asserts. The gate is closed in the first frame after enable.
- R3: A frame whose first received bit (frame bit 0) is 0 writes nothing to the receive port. The first frame after enable counts as such a frame until its bit 0 is seen as 1.
- R4: A frame whose bit 0 is 1 writes 13 words in slot order. Slot 0 is frame bits 0..15, placed in word bits 31..16 with bits 15..0 zero. Slot k (1..12) is frame bits 16+20(k-1) .. 35+20(k-1), placed in bits 31..12 with bits 11..0 zero. Earlier bits go to higher word bits. Each write is a one-cycle rx_valid_o pulse in the cycle after the slot's last bit.
- R5: The transmit gate of frame f is open exactly when the bit 0 received in frame f-1 was 1. In an open frame, tx_ready_o is high in cycle 0 of the frame and in cycles 16+20k (k = 0..11), so there are 13 requests per frame.
- R6: A frame whose received bit 0 is 0 is still transmitted in full if its own gate was open. The following frame is silent.
- R7: Frame bit p is on sdi_i and on sdo_o during frame cycle p+1 (bit 255 during cycle 0 of the next frame). sdi_i is sampled on the falling clock edge and sdo_o changes on the rising edge. The word taken at a request is sent MSB first, starting in the next cycle.
- R8: When a request in an open frame finds tx_valid_i low, that slot is sent as zeros and tx_underrun_o rises in the next cycle. It stays high until en_i goes low.
- R9: While en_i is low or the block is in reset, sync_o, sdo_o, tx_ready_o, rx_valid_o and tx_underrun_o are 0 (the registered outputs from the first clock edge on). Frame timing and the codec-ready state restart from the beginning when en_i rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock from the codec |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Runs the link; low holds everything idle |
| sync_o | output | 1 | Frame sync to the codec |
| sdo_o | output | 1 | Serial data to the codec |
| sdi_i | input | 1 | Serial data from the codec |
| tx_data_i | input | 32 | Transmit FIFO head word |
| tx_valid_i | input | 1 | Transmit FIFO has a word |
| tx_ready_o | output | 1 | Takes the head word at this clock edge |
| rx_data_o | output | 32 | Received slot word |
| rx_valid_o | output | 1 | Write strobe for rx_data_o |
| tx_underrun_o | output | 1 | Sticky: a slot was sent empty |

## Verification
The codec model drives a sequence of frames whose ready bits run 0,1,1,0,0,1,1,1,0,1,0. This covers a first ready frame, a ready frame that follows a not-ready one, and single and double gaps, so the bench can tell a one-frame start delay apart from an immediate start and an end-of-frame stop apart from a mid-frame stop. Every slot carries a distinct value derived from its frame and slot number, so a swapped order, a misaligned field or a dropped bit changes the comparison. A hole in the transmit FIFO covers one slot of an open frame. This separates a zero-filled slot plus a sticky flag from a stall or a shift. A disable and re-enable then show that timing and codec-ready state restart and that the flag clears.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;

  typedef struct packed {
    logic frame_start;  // frame cycle 0
    logic slot_start;   // first cycle of a slot (also last rx bit of previous slot)
    logic first_bit;    // frame cycle 1: bit 0 is on the line
  } tick_t;

  function automatic int frame_bits(int s0_w, int s_w, int n_slots);
    return s0_w + (n_slots - 1) * s_w;
  endfunction

endpackage

// File: rtl/ac_link_timer.sv
module ac_link_timer
  import ac_link_pkg::*;
#(
  parameter int SLOT0_W   = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 13,
  parameter int SYNC_HI   = 16,
  parameter int FRAME_LEN = 256,
  parameter int POS_W     = 8,
  parameter int IDX_W     = 4,
  parameter int BIT_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [IDX_W-1:0] idx_o,
  output tick_t            tick_o,
  output logic             sync_o
);

  localparam logic [POS_W-1:0] LastPos = POS_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_SLOTS - 1);
  localparam logic [BIT_W-1:0] S0Left  = BIT_W'(SLOT0_W - 1);
  localparam logic [BIT_W-1:0] SLeft   = BIT_W'(SLOT_W - 1);

  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;
  logic [BIT_W-1:0] left_q;
  logic             first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      idx_q   <= '0;
      left_q  <= S0Left;
      first_q <= 1'b1;
    end else if (!en_i) begin
      pos_q   <= '0;
      idx_q   <= '0;
      left_q  <= S0Left;
      first_q <= 1'b1;
    end else begin
      pos_q <= (pos_q == LastPos) ? '0 : pos_q + 1'b1;
      if (left_q == '0) begin
        first_q <= 1'b1;
        if (idx_q == LastIdx) begin
          idx_q  <= '0;
          left_q <= S0Left;
        end else begin
          idx_q  <= idx_q + 1'b1;
          left_q <= SLeft;
        end
      end else begin
        first_q <= 1'b0;
        left_q  <= left_q - 1'b1;
      end
    end
  end

  assign idx_o              = idx_q;
  assign tick_o.frame_start = en_i && (pos_q == '0);
  assign tick_o.slot_start  = en_i && first_q;
  assign tick_o.first_bit   = en_i && (pos_q == POS_W'(1));
  assign sync_o             = en_i && (pos_q < POS_W'(SYNC_HI));

endmodule

// File: rtl/ac_link_rx.sv
module ac_link_rx
  import ac_link_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SLOT0_W = 16,
  parameter int SLOT_W  = 20,
  parameter int IDX_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sdi_i,
  input  tick_t             tick_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              sdi_smp_o,
  output logic              frame_rdy_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  logic              sdi_q;
  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-1:0] sh_n;
  logic              rdy_q;
  logic [WORD_W-1:0] word;
  logic              ends_slot0;

  // codec data is stable around the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdi_q <= 1'b0;
    else         sdi_q <= sdi_i;
  end

  assign sh_n       = {sh_q, sdi_q};
  assign ends_slot0 = (idx_i == IDX_W'(1));

  always_comb begin
    if (ends_slot0) word = {sh_n[SLOT0_W-1:0], {(WORD_W-SLOT0_W){1'b0}}};
    else            word = {sh_n, {(WORD_W-SLOT_W){1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      rdy_q      <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else if (!en_i) begin
      sh_q       <= '0;
      rdy_q      <= 1'b0;
      rx_valid_o <= 1'b0;
    end else begin
      sh_q       <= sh_n[SLOT_W-2:0];
      if (tick_i.first_bit) rdy_q <= sdi_q;
      rx_valid_o <= tick_i.slot_start && rdy_q;
      if (tick_i.slot_start && rdy_q) rx_data_o <= word;
    end
  end

  assign sdi_smp_o   = sdi_q;
  assign frame_rdy_o = rdy_q;

endmodule

// File: rtl/ac_link_tx.sv
module ac_link_tx
  import ac_link_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  tick_t             tick_i,
  input  logic              codec_rdy_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              sdo_o,
  output logic              tx_underrun_o
);

  logic              on_q;
  logic              frame_on;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] load;

  // gate for the frame that starts now comes from the last sampled ready bit
  assign frame_on   = tick_i.frame_start ? codec_rdy_i : on_q;
  assign tx_ready_o = en_i && tick_i.slot_start && frame_on;
  assign load       = (frame_on && tx_valid_i) ? tx_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q          <= 1'b0;
      sh_q          <= '0;
      sdo_o         <= 1'b0;
      tx_underrun_o <= 1'b0;
    end else if (!en_i) begin
      on_q          <= 1'b0;
      sh_q          <= '0;
      sdo_o         <= 1'b0;
      tx_underrun_o <= 1'b0;
    end else begin
      if (tick_i.frame_start) on_q <= codec_rdy_i;
      if (tick_i.slot_start) begin
        sdo_o <= load[WORD_W-1];
        sh_q  <= {load[WORD_W-2:0], 1'b0};
        if (frame_on && !tx_valid_i) tx_underrun_o <= 1'b1;
      end else begin
        sdo_o <= sh_q[WORD_W-1];
        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/ac_link_engine.sv
module ac_link_engine
  import ac_link_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SLOT0_W   = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 13,
  parameter int SYNC_HI   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic              sync_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_underrun_o
);

  localparam int FrameLen = frame_bits(SLOT0_W, SLOT_W, NUM_SLOTS);
  localparam int PosW     = $clog2(FrameLen);
  localparam int IdxW     = $clog2(NUM_SLOTS);
  localparam int BitW     = $clog2((SLOT_W > SLOT0_W) ? SLOT_W : SLOT0_W);

  tick_t            tick;
  logic [IdxW-1:0]  slot_idx;
  logic             sdi_smp;
  logic             frame_rdy;

  ac_link_timer #(
    .SLOT0_W(SLOT0_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .SYNC_HI(SYNC_HI),
    .FRAME_LEN(FrameLen), .POS_W(PosW), .IDX_W(IdxW), .BIT_W(BitW)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .idx_o (slot_idx),
    .tick_o(tick),
    .sync_o(sync_o)
  );

  ac_link_rx #(
    .WORD_W(WORD_W), .SLOT0_W(SLOT0_W), .SLOT_W(SLOT_W), .IDX_W(IdxW)
  ) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .sdi_i      (sdi_i),
    .tick_i     (tick),
    .idx_i      (slot_idx),
    .sdi_smp_o  (sdi_smp),
    .frame_rdy_o(frame_rdy),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  ac_link_tx #(
    .WORD_W(WORD_W)
  ) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .tick_i       (tick),
    .codec_rdy_i  (frame_rdy),
    .tx_data_i    (tx_data_i),
    .tx_valid_i   (tx_valid_i),
    .tx_ready_o   (tx_ready_o),
    .sdo_o        (sdo_o),
    .tx_underrun_o(tx_underrun_o)
  );

endmodule

// File: rtl/ac_link_engine_chk.sv
module ac_link_engine_chk #(
  parameter int SYNC_HI = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sync_o,
  input logic sdo_o,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic tx_underrun_o,
  input logic frame_start_i,
  input logic slot_start_i,
  input logic first_bit_i,
  input logic sdi_smp_i
);

  int unsigned hi_cnt;
  logic        rdy_c;
  logic        gate_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= 0;
      rdy_c  <= 1'b0;
      gate_c <= 1'b0;
    end else begin
      hi_cnt <= sync_o ? hi_cnt + 1 : 0;
      if (!en_i) begin
        rdy_c  <= 1'b0;
        gate_c <= 1'b0;
      end else begin
        if (first_bit_i)   rdy_c  <= sdi_smp_i;
        if (frame_start_i) gate_c <= rdy_c;
      end
    end
  end

  p_sync_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (hi_cnt < SYNC_HI));

  p_sync_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> frame_start_i);

  p_pop_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (frame_start_i ? rdy_c : gate_c));

  p_rx_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rdy_c));

  p_pop_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> slot_start_i);

  p_underrun_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(tx_underrun_o)) |-> tx_underrun_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> (!sdo_o && !rx_valid_o && !tx_ready_o && !sync_o && !tx_underrun_o));

endmodule

bind ac_link_engine ac_link_engine_chk #(.SYNC_HI(SYNC_HI)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .sync_o       (sync_o),
  .sdo_o        (sdo_o),
  .tx_ready_o   (tx_ready_o),
  .rx_valid_o   (rx_valid_o),
  .tx_underrun_o(tx_underrun_o),
  .frame_start_i(tick.frame_start),
  .slot_start_i (tick.slot_start),
  .first_bit_i  (tick.first_bit),
  .sdi_smp_i    (sdi_smp)
);

// File: tb/ac_link_engine_tb_top.sv
`timescale 1ns/1ps
module ac_link_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        sync_o, sdo_o, tx_ready_o, rx_valid_o, tx_underrun_o;
  logic [31:0] rx_data_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ac_link_engine dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .sync_o(sync_o), .sdo_o(sdo_o),
    .sdi_i(sdi_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .tx_underrun_o(tx_underrun_o)
  );

  bit          rdy [0:15];
  int          hole_frame;
  int          pop_k = 0;
  logic [31:0] rxq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] rbits(int f, int s);
    return 20'((f * 97 + s * 31 + 5) * 40503);
  endfunction

  function automatic logic [31:0] rx_word(int f, int s);
    logic [19:0] b = rbits(f, s);
    if (s == 0) return {rdy[f], b[14:0], 16'h0};
    return {b, 12'h0};
  endfunction

  function automatic bit rx_bit(int f, int p);
    logic [31:0] w;
    int s, o;
    if (p < 16) begin s = 0; o = p; end
    else begin s = 1 + (p - 16) / 20; o = (p - 16) % 20; end
    w = rx_word(f, s);
    return w[31-o];
  endfunction

  function automatic bit isb(int c);
    return (c == 0) || (c >= 16 && (c - 16) % 20 == 0);
  endfunction

  function automatic logic [31:0] txgen(int k);
    return 32'(k) * 32'h9E3779B1 + 32'h01357A2B;
  endfunction

  task automatic run_frames(input int nf);
    logic [31:0] exp_sh = '0;
    logic [31:0] w;
    logic        exp_sdo = 1'b0;
    bit          popped = 0;
    bit          on_fr = 0;
    bit          exp_und = 0;
    bit          exp_v;
    int          c, fr;
    string       tg;
    for (int f = 0; f < nf; f++)
      if (rdy[f])
        for (int s = 0; s < 13; s++) rxq.push_back(rx_word(f, s));
    for (int t = 0; t <= nf * 256 + 1; t++) begin
      if (t > 0) begin
        @(posedge clk);
        #1;
        if (popped) pop_k++;
      end
      c  = t % 256;
      fr = t / 256;
      en_i       = 1'b1;
      tx_valid_i = !(fr == hole_frame && c >= 56 && c < 76);
      tx_data_i  = txgen(pop_k);
      sdi_i      = (t >= 1 && (t - 1) / 256 < nf) ? rx_bit((t - 1) / 256, (t - 1) % 256) : 1'b0;
      #0.2;
      chk(sync_o == (c < 16), "R1", "sync_o", sync_o, (c < 16));
      chk(sdo_o == exp_sdo, "R7", "sdo_o bit", sdo_o, exp_sdo);
      chk(tx_underrun_o == exp_und, "R8", "tx_underrun_o", tx_underrun_o, exp_und);
      if (c == 0) on_fr = (fr >= 1) && rdy[fr-1];
      if (on_fr)                       tg = "R5";
      else if (fr >= 2 && rdy[fr-2])   tg = "R6";
      else                             tg = "R2";
      chk(tx_ready_o == (isb(c) && on_fr), tg, "tx_ready_o", tx_ready_o, (isb(c) && on_fr));
      if (isb(c)) begin
        w = (on_fr && tx_valid_i) ? tx_data_i : 32'h0;
        exp_sdo = w[31];
        exp_sh  = {w[30:0], 1'b0};
        if (on_fr && !tx_valid_i) exp_und = 1;
      end else begin
        exp_sdo = exp_sh[31];
        exp_sh  = {exp_sh[30:0], 1'b0};
      end
      popped = tx_ready_o && tx_valid_i;
      exp_v = (t >= 2) && isb((t - 1) % 256) && rdy[(t - 2) / 256];
      chk(rx_valid_o == exp_v, "R3", "rx_valid_o", rx_valid_o, exp_v);
      if (rx_valid_o) begin
        if (rxq.size() == 0) chk(0, "R4", "rx word beyond 13 per ready frame", rx_data_o, 0);
        else begin
          w = rxq.pop_front();
          chk(rx_data_o == w, "R4", "rx_data_o", rx_data_o, w);
        end
      end
    end
    chk(rxq.size() == 0, "R4", "rx words left unwritten", rxq.size(), 0);
    rxq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!sync_o && !sdo_o && !tx_ready_o && !rx_valid_o && !tx_underrun_o, "R9", "outputs in reset",
        {sync_o, sdo_o, tx_ready_o, rx_valid_o, tx_underrun_o}, 0);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    chk(!sync_o && !sdo_o && !tx_ready_o, "R9", "outputs while disabled", {sync_o, sdo_o, tx_ready_o}, 0);

    // run 1: ready pattern with gaps, one empty slot in an open frame
    for (int i = 0; i < 16; i++) rdy[i] = 0;
    rdy[1] = 1; rdy[2] = 1; rdy[5] = 1; rdy[6] = 1; rdy[7] = 1; rdy[9] = 1;
    hole_frame = 6;
    run_frames(11);
    chk(tx_underrun_o == 1'b1, "R8", "underrun held after run", tx_underrun_o, 1);

    // disable with busy inputs: nothing moves, flag clears
    en_i = 1'b0; sdi_i = 1'b1; tx_valid_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      #1;
      chk(!sync_o && !sdo_o && !tx_ready_o && !rx_valid_o, "R9", "idle outputs",
          {sync_o, sdo_o, tx_ready_o, rx_valid_o}, 0);
      chk(!tx_underrun_o, "R8", "underrun cleared by disable", tx_underrun_o, 0);
    end

    // run 2: restart, ready from the first frame
    for (int i = 0; i < 16; i++) rdy[i] = 0;
    rdy[0] = 1; rdy[1] = 1;
    hole_frame = -1;
    run_frames(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule